// File: doc/BRIEF.md
# Serial Port Control and Status Register File

This block is the software-visible register file of a serial port controller. A host reads and writes it over a simple bus of 32-bit words. The bus has an address, a size code, separate read and write strobes, write data and registered read data. The block holds three control words, a baud divisor, a guard-time/prescaler word and a receiver timeout word. It also keeps an interrupt status word and the receive and transmit character registers. Status bits are cleared in two ways: by writing ones to a dedicated clear register, or, for the receive-not-empty flag, by reading the received character.

A second port faces the serial datapath. The transmitter takes the current transmit character from `tx_data`. The receiver drops a new character in with `rx_load`/`rx_char` and can raise any status bit with `flag_set`. The stored configuration is driven out continuously to the shifting and baud logic. That logic sits outside this block. A single interrupt line combines four status flags with their enables.

Word offsets, by index: 0 control 1, 1 control 2, 2 control 3, 3 baud, 4 guard/prescaler, 5 receiver timeout, 6 request, 7 status, 8 clear, 9 receive data, 10 transmit data (byte address = 4 × index). Size code `bus_size`: 2'b10 is a 32-bit access; 2'b00, 2'b01 and 2'b11 are narrower or invalid.

Top module: `serial_csr_file`

## Requirements
- R1: After reset, reading any of the eleven registers returns zero, except the status register. Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.
- R2: The status register resets to 0x020000C0, so transmit-empty (bit 7), transmission-complete (bit 6) and bit 25 are set.
- R3: Control 1, control 2, control 3, guard/prescaler and receiver timeout store and read back all 32 written bits. Control 1, control 2, control 3, guard/prescaler and receiver timeout are also driven on `ctl1_q`, `ctl2_q`, `ctl3_q`, `guard_q` and `tmo_q`.
- R4: A baud register read returns only bits [15:0]. A transmit register read returns only bits [8:0]. `tx_data` and `baud_q` show those stored bits.
- R5: A read of the receive register returns the stored 9-bit character in bits [8:0] and clears status bit 5 (receive-not-empty).
- R6: A pulse on `rx_load` stores `rx_char` in the receive register and sets status bit 5. If it coincides with a bus read of the receive register, the read returns the old character and bit 5 ends up set.
- R7: A write to the clear register (index 8) clears each status bit whose position is 1 in the written value. The clear register and the request register (index 6) always read zero.
- R8: Writes to the request, status and receive registers change no stored state.
- R9: An access is rejected when the size is not 2'b10, the address is not word-aligned, or the index is above 10. A rejected access changes no state, and a rejected read returns zero. Each rejected access drives `bus_err` high for exactly the one following cycle.
- R10: `irq` is high exactly when any of status bits 7..4 is set together with the control 1 bit at the same position (bits 7, 6, 5, 4).
- R11: Each 1 bit of `flag_set` sets that status bit at the next clock edge. A set takes priority over a clear to the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (10) | Byte address of the access |
| bus_size | input | 2 | Access size code, 2'b10 = 32-bit word |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a rejected access |
| rx_load | input | 1 | Receiver strobe: store a new character |
| rx_char | input | 9 | Received character |
| flag_set | input | 32 | Per-bit status set requests from the datapath |
| tx_data | output | 9 | Current transmit character |
| ctl1_q | output | 32 | Control word 1 |
| ctl2_q | output | 32 | Control word 2 |
| ctl3_q | output | 32 | Control word 3 |
| baud_q | output | 16 | Baud divisor |
| guard_q | output | 32 | Guard time and prescaler word |
| tmo_q | output | 32 | Receiver timeout word |
| irq | output | 1 | Combined interrupt |

## Verification
The bench walks every offset with several data patterns and compares each read against a register model. A decoder that aliased offsets or failed to trim the baud and character fields would show up as wrong read-back. It clears all 32 status bits one at a time and sweeps all 256 combinations of enables against flags. A clear mask applied to the wrong bit, or an interrupt taken from an unenabled flag, would then be caught. It also hits the two same-cycle collisions, a character arriving during a receive read and a set meeting a clear, where a design with the wrong priority would lose a flag. Finally, it sends narrow, misaligned and out-of-map accesses, some aimed at the clear register. A design that let these through would wipe status bits or corrupt configuration.

// File: rtl/sercsr_pkg.sv
package sercsr_pkg;

    localparam int NUM_REGS = 11;
    localparam int DATA_W   = 32;
    localparam int CHAR_W   = 9;
    localparam int BAUD_W   = 16;
    localparam int RXNE_POS = 5;
    localparam int IRQ_LO   = 4;
    localparam int IRQ_HI   = 7;

    localparam logic [1:0]        SIZE_WORD  = 2'b10;
    localparam logic [DATA_W-1:0] STAT_RESET = 32'h0200_00C0;

    typedef enum logic [3:0] {
        IDX_CTL1  = 4'd0,
        IDX_CTL2  = 4'd1,
        IDX_CTL3  = 4'd2,
        IDX_BAUD  = 4'd3,
        IDX_GUARD = 4'd4,
        IDX_TMO   = 4'd5,
        IDX_REQ   = 4'd6,
        IDX_STAT  = 4'd7,
        IDX_CLR   = 4'd8,
        IDX_RXD   = 4'd9,
        IDX_TXD   = 4'd10
    } reg_idx_e;

    // Decoded bus access, one-hot per register
    typedef struct packed {
        logic [NUM_REGS-1:0] wr;
        logic [NUM_REGS-1:0] rd;
        logic                bad;
    } acc_t;

    // Bits kept by the generic storage bank for each index (0 = no storage there)
    function automatic logic [DATA_W-1:0] store_mask(int idx);
        case (idx)
            IDX_CTL1, IDX_CTL2, IDX_CTL3,
            IDX_GUARD, IDX_TMO:  store_mask = '1;
            IDX_BAUD:            store_mask = DATA_W'({BAUD_W{1'b1}});
            IDX_TXD:             store_mask = DATA_W'({CHAR_W{1'b1}});
            default:             store_mask = '0;
        endcase
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import sercsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              we,
    input  logic              re,
    output acc_t              acc
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] word_idx;
    logic              legal;

    assign word_idx = addr[ADDR_W-1:2];
    assign legal    = (size == SIZE_WORD) && (addr[1:0] == 2'b00)
                      && (word_idx < WIDX_W'(NUM_REGS));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        logic sel;
        assign sel       = legal && (word_idx == WIDX_W'(g));
        assign acc.wr[g] = sel && we;
        assign acc.rd[g] = sel && re;
    end

    assign acc.bad = (we || re) && !legal;

endmodule

// File: rtl/csr_store_bank.sv
module csr_store_bank
    import sercsr_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_REGS-1:0]              wr_hit,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  q
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [DATA_W-1:0] KEEP = store_mask(g);
        if (KEEP != '0) begin : g_store
            logic [DATA_W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst)            r <= '0;
                else if (wr_hit[g]) r <= wdata & KEEP;
            end
            assign q[g] = r;
        end else begin : g_none
            assign q[g] = '0;
        end
    end

endmodule

// File: rtl/csr_status_reg.sv
module csr_status_reg
    import sercsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_val,
    input  logic              rxd_read,
    input  logic [DATA_W-1:0] set_vec,
    input  logic              rx_load,
    input  logic [CHAR_W-1:0] rx_char,
    output logic [DATA_W-1:0] stat_q,
    output logic [CHAR_W-1:0] rxd_q
);
    logic [DATA_W-1:0] drop, raise, stat_d;

    always_comb begin
        drop = clr_en ? clr_val : '0;
        if (rxd_read) drop[RXNE_POS] = 1'b1;
        raise = set_vec;
        if (rx_load) raise[RXNE_POS] = 1'b1;
        // raising wins over any clear in the same cycle
        stat_d = (stat_q & ~drop) | raise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= STAT_RESET;
            rxd_q  <= '0;
        end else begin
            stat_q <= stat_d;
            if (rx_load) rxd_q <= rx_char;
        end
    end

endmodule

// File: rtl/serial_csr_file.sv
module serial_csr_file
    import sercsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic              rx_load,
    input  logic [8:0]        rx_char,
    input  logic [31:0]       flag_set,
    output logic [8:0]        tx_data,
    output logic [31:0]       ctl1_q,
    output logic [31:0]       ctl2_q,
    output logic [31:0]       ctl3_q,
    output logic [15:0]       baud_q,
    output logic [31:0]       guard_q,
    output logic [31:0]       tmo_q,
    output logic              irq
);
    acc_t                            acc;
    logic [NUM_REGS-1:0][DATA_W-1:0] cfg_q;
    logic [NUM_REGS-1:0][DATA_W-1:0] view;
    logic [DATA_W-1:0]               stat_q;
    logic [CHAR_W-1:0]               rxd_q;
    logic [DATA_W-1:0]               rd_val;

    csr_addr_decode #(.ADDR_W(ADDR_W)) i_dec (
        .addr (bus_addr),
        .size (bus_size),
        .we   (bus_we),
        .re   (bus_re),
        .acc  (acc)
    );

    csr_store_bank i_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (acc.wr),
        .wdata  (bus_wdata),
        .q      (cfg_q)
    );

    csr_status_reg i_stat (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (acc.wr[IDX_CLR]),
        .clr_val  (bus_wdata),
        .rxd_read (acc.rd[IDX_RXD]),
        .set_vec  (flag_set),
        .rx_load  (rx_load),
        .rx_char  (rx_char),
        .stat_q   (stat_q),
        .rxd_q    (rxd_q)
    );

    // Read view: stored bank words plus the status and receive registers
    always_comb begin
        view           = cfg_q;
        view[IDX_STAT] = stat_q;
        view[IDX_RXD]  = DATA_W'(rxd_q);
        rd_val = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (acc.rd[i]) rd_val = rd_val | view[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= acc.bad;
            if (bus_re) bus_rdata <= rd_val;
        end
    end

    assign ctl1_q  = cfg_q[IDX_CTL1];
    assign ctl2_q  = cfg_q[IDX_CTL2];
    assign ctl3_q  = cfg_q[IDX_CTL3];
    assign baud_q  = cfg_q[IDX_BAUD][BAUD_W-1:0];
    assign guard_q = cfg_q[IDX_GUARD];
    assign tmo_q   = cfg_q[IDX_TMO];
    assign tx_data = cfg_q[IDX_TXD][CHAR_W-1:0];
    assign irq     = |(stat_q[IRQ_HI:IRQ_LO] & cfg_q[IDX_CTL1][IRQ_HI:IRQ_LO]);

endmodule

// File: rtl/serial_csr_file_chk.sv
module serial_csr_file_chk
    import sercsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_we,
    input logic              bus_re,
    input logic              bus_err,
    input logic              rx_load,
    input logic [31:0]       flag_set,
    input logic [31:0]       stat,
    input logic [31:0]       ctl1,
    input logic              irq
);
    logic word_ok, rejected, rxd_rd, stat_wr, quiet;

    assign word_ok  = (bus_size == 2'b10) && (bus_addr[1:0] == 2'b00)
                      && (bus_addr[ADDR_W-1:2] < (ADDR_W-2)'(NUM_REGS));
    assign rejected = (bus_we || bus_re) && !word_ok;
    assign rxd_rd   = bus_re && word_ok && (bus_addr == ADDR_W'(36));
    assign stat_wr  = bus_we && word_ok && (bus_addr == ADDR_W'(28));
    assign quiet    = !rx_load && (flag_set == 32'd0);

    // R2
    a_r2_reset_value: assert property (@(posedge clk)
        rst |=> stat == STAT_RESET);

    // R5
    a_r5_read_clears_rxne: assert property (@(posedge clk) disable iff (rst)
        (rxd_rd && quiet) |=> !stat[RXNE_POS]);

    // R6
    a_r6_load_sets_rxne: assert property (@(posedge clk) disable iff (rst)
        rx_load |=> stat[RXNE_POS]);

    // R8
    a_r8_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && quiet && !rxd_rd) |=> $stable(stat));

    // R9
    a_r9_reject_keeps_status: assert property (@(posedge clk) disable iff (rst)
        (rejected && quiet) |=> $stable(stat));

    a_r9_err_follows_reject: assert property (@(posedge clk) disable iff (rst)
        rejected |=> bus_err);

    a_r9_err_only_after_reject: assert property (@(posedge clk) disable iff (rst)
        !rejected |=> !bus_err);

    // R10
    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (ctl1[7:4] == 4'b0000) |-> !irq);

endmodule

bind serial_csr_file serial_csr_file_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_err  (bus_err),
    .rx_load  (rx_load),
    .flag_set (flag_set),
    .stat     (stat_q),
    .ctl1     (ctl1_q),
    .irq      (irq)
);

// File: tb/test_serial_csr_file.sv
module test_serial_csr_file;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = 2'b10;
    logic          bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_err;
    logic          rx_load = 1'b0;
    logic [8:0]    rx_char = '0;
    logic [31:0]   flag_set = '0;
    logic [8:0]    tx_data;
    logic [31:0]   ctl1_q, ctl2_q, ctl3_q, guard_q, tmo_q;
    logic [15:0]   baud_q;
    logic          irq;

    int n_run = 0, n_fail = 0;

    // Register model
    logic [31:0] mdl [0:10];
    logic [31:0] st_m;
    logic [8:0]  rxd_m;

    always #5 clk = ~clk;

    serial_csr_file #(.ADDR_W(AW)) i_serial_csr_file (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .rx_load(rx_load),
        .rx_char(rx_char), .flag_set(flag_set), .tx_data(tx_data),
        .ctl1_q(ctl1_q), .ctl2_q(ctl2_q), .ctl3_q(ctl3_q), .baud_q(baud_q),
        .guard_q(guard_q), .tmo_q(tmo_q), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int i);
        case (i)
            0, 1, 2, 4, 5: exp_rd = mdl[i];
            3:             exp_rd = mdl[3] & 32'h0000_FFFF;
            7:             exp_rd = st_m;
            9:             exp_rd = {23'd0, rxd_m};
            10:            exp_rd = mdl[10] & 32'h0000_01FF;
            default:       exp_rd = 32'd0;
        endcase
    endfunction

    function automatic logic exp_irq();
        exp_irq = |(st_m[7:4] & mdl[0][7:4]);
    endfunction

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [1:0] sz, output logic [31:0] rd, output logic er);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d;
        bus_we = wr; bus_re = !wr;
        @(negedge clk);
        rd = bus_rdata; er = bus_err;
        bus_we = 1'b0; bus_re = 1'b0; bus_size = 2'b10;
    endtask

    task automatic wr_reg(input int i, input logic [31:0] d);
        logic [31:0] r; logic e;
        access(1'b1, AW'(i * 4), d, 2'b10, r, e);
        if (i <= 5 || i == 10) mdl[i] = d;
        if (i == 8) st_m = st_m & ~d;
    endtask

    task automatic rd_reg(input int i, output logic [31:0] r);
        logic e;
        access(1'b0, AW'(i * 4), 32'd0, 2'b10, r, e);
        if (i == 9) st_m[5] = 1'b0;
    endtask

    task automatic pulse_set(input logic [31:0] v);
        @(negedge clk);
        flag_set = v;
        @(negedge clk);
        flag_set = '0;
        st_m = st_m | v;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] r;
        for (int i = 0; i <= 10; i++) begin
            logic [31:0] e;
            e = exp_rd(i);
            rd_reg(i, r);
            chk(tag, r, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        e;
        logic [31:0] pats [0:2];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A; pats[2] = 32'h1234_5678;
        for (int i = 0; i <= 10; i++) mdl[i] = '0;
        st_m = 32'h0200_00C0;
        rxd_m = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 err idle", {31'd0, bus_err}, 32'd0);
        chk("R10 irq at reset", {31'd0, irq}, 32'd0);
        chk("R4 tx_data reset", {23'd0, tx_data}, 32'd0);
        // R1 and R2: reset read-back of every register
        check_all("R1/R2 reset readback");

        // R3 R4 R8: pattern sweep over every offset except the clear register
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i <= 10; i++) begin
                if (i != 8) wr_reg(i, pats[p] ^ (32'h0101_0101 * i));
            end
            check_all("R3/R4/R8 sweep readback");
            chk("R3 ctl1 port", ctl1_q, mdl[0]);
            chk("R3 ctl2 port", ctl2_q, mdl[1]);
            chk("R3 ctl3 port", ctl3_q, mdl[2]);
            chk("R3 guard port", guard_q, mdl[4]);
            chk("R3 tmo port", tmo_q, mdl[5]);
            chk("R4 baud port", {16'd0, baud_q}, mdl[3] & 32'hFFFF);
            chk("R4 tx_data port", {23'd0, tx_data}, mdl[10] & 32'h1FF);
            chk("R10 irq after sweep", {31'd0, irq}, {31'd0, exp_irq()});
        end

        // R7 R11: per-bit set then clear through the clear register
        for (int b = 0; b < 32; b++) begin
            pulse_set(32'd1 << b);
            rd_reg(7, r);
            chk("R11 flag_set sets bit", r, st_m);
            wr_reg(8, 32'd1 << b);
            rd_reg(7, r);
            chk("R7 clear bit", r, st_m);
        end
        chk("R7 all cleared", st_m, 32'd0);

        // R10: every enable against every flag pattern in bits 7..4
        for (int en = 0; en < 16; en++) begin
            wr_reg(0, 32'(en) << 4);
            for (int s = 0; s < 16; s++) begin
                wr_reg(8, 32'hFFFF_FFFF);
                pulse_set(32'(s) << 4);
                @(negedge clk);
                chk("R10 irq combination", {31'd0, irq}, {31'd0, exp_irq()});
            end
        end
        wr_reg(0, 32'd0);
        wr_reg(8, 32'hFFFF_FFFF);

        // R6 R5: load a character, read it, flag drops
        @(negedge clk);
        rx_load = 1'b1; rx_char = 9'h1A5;
        @(negedge clk);
        rx_load = 1'b0;
        rxd_m = 9'h1A5; st_m[5] = 1'b1;
        rd_reg(7, r);
        chk("R6 load sets rxne", r, st_m);
        rd_reg(9, r);
        chk("R5 rxd read value", r, 32'h0000_01A5);
        rd_reg(7, r);
        chk("R5 rxd read clears rxne", r, st_m);

        // R6: load coincides with rxd read
        @(negedge clk);
        rx_load = 1'b1; rx_char = 9'h0F3;
        bus_addr = AW'(36); bus_size = 2'b10; bus_re = 1'b1;
        @(negedge clk);
        r = bus_rdata;
        rx_load = 1'b0; bus_re = 1'b0;
        chk("R6 collision returns old char", r, 32'h0000_01A5);
        rxd_m = 9'h0F3; st_m[5] = 1'b1;
        rd_reg(7, r);
        chk("R6 collision keeps rxne", r, st_m);
        rd_reg(9, r);
        chk("R6 new char stored", r, 32'h0000_00F3);

        // R11: set and clear of the same bit in one cycle
        @(negedge clk);
        flag_set = 32'h0000_1000;
        bus_addr = AW'(32); bus_size = 2'b10; bus_we = 1'b1; bus_wdata = 32'h0000_1000;
        @(negedge clk);
        flag_set = '0; bus_we = 1'b0;
        st_m = st_m | 32'h0000_1000;
        rd_reg(7, r);
        chk("R11 set beats clear", r, st_m);

        // R9: rejected accesses with all status bits set
        pulse_set(32'hFFFF_FFFF);
        for (int i = 0; i <= 10; i++) begin
            for (int sz = 0; sz < 4; sz++) begin
                if (sz != 2) begin
                    access(1'b1, AW'(i * 4), 32'hFFFF_FFFF, 2'(sz), r, e);
                    chk("R9 narrow write err", {31'd0, e}, 32'd1);
                    access(1'b0, AW'(i * 4), 32'd0, 2'(sz), r, e);
                    chk("R9 narrow read zero", r, 32'd0);
                end
            end
            for (int off = 1; off < 4; off++) begin
                access(1'b1, AW'(i * 4 + off), 32'hFFFF_FFFF, 2'b10, r, e);
                chk("R9 unaligned err", {31'd0, e}, 32'd1);
            end
        end
        for (int a = 44; a < (1 << AW); a += 4) begin
            access(1'b1, AW'(a), 32'hFFFF_FFFF, 2'b10, r, e);
            chk("R9 out of map write err", {31'd0, e}, 32'd1);
            access(1'b0, AW'(a), 32'd0, 2'b10, r, e);
            chk("R9 out of map read zero", {r[31:1], e}, 32'd1);
            @(negedge clk);
            chk("R9 err single cycle", {31'd0, bus_err}, 32'd0);
        end
        check_all("R9 state unchanged after rejects");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule